// File: doc/BRIEF.md
# Two-Bank Level/Edge Interrupt Controller

This block gathers a set of interrupt request lines and presents them to a processor on two outputs: a normal-priority request and a fast request. Each output has its own bank of registers. Within a bank, software chooses for every line whether it is sensed as a level or as an edge, and which sense counts as active. Software also chooses whether the line may reach that bank's output at all.

Edges are held in sticky pending bits until software acknowledges them through a write-one-to-clear register. A bank's status register shows the lines that are both pending and enabled, and the bank output is a registered OR of that status. Software reads status, services the lowest set bit, acknowledges it and reads again.

Inputs are synchronised by a two-flop chain before any detection. A plain synchronous register bus writes in the cycle it is selected and returns read data in the following cycle.

Top module: `intc_dualbank`

## Requirements
- R1: The normal bank sits at byte offsets 0x00 (source, read-only), 0x04 (enable), 0x08 (acknowledge), 0x0C (trigger mode), 0x10 (polarity) and 0x14 (status, read-only). The fast bank repeats this layout at 0x20 through 0x34. Bit i of every register belongs to line i. Enable, mode and polarity read back the value last written.
- R2: After reset, enable, mode, polarity and all edge pending bits are 0, and both outputs are low.
- R3: An enable bit of 1 lets the line into status and the output. With an enable bit of 0 the status bit and the output stay 0, while the source register still shows the pending line.
- R4: A polarity bit of 0 selects active-high level or rising edge. A polarity bit of 1 selects active-low level or falling edge.
- R5: A mode bit of 1 selects edge detection. A mode bit of 0 selects level detection, in which the source bit equals the synchronised input XOR the polarity bit.
- R6: In edge mode a detected edge sets a source bit, and the bit stays set until a 1 is written to its acknowledge bit. Acknowledge bits written as 0 change nothing. An edge detected in the same cycle as its acknowledge leaves the bit set.
- R7: Writing the acknowledge register has no lasting effect on a level-mode line. The acknowledge register reads as 0.
- R8: Status equals source AND enable. The bank output is a register holding the OR of status. A level change on an input reaches the output at the third rising clock edge after it is applied.
- R9: The two banks share the input lines but have independent enable, mode, polarity and pending state.
- R10: Read data appears on the rising edge after the read request. Addresses outside the twelve mapped registers read as 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | NUM_LINES | Asynchronous interrupt request lines |
| bus_sel | input | 1 | Register access request this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | NUM_LINES | Write data |
| bus_rdata | output | NUM_LINES | Read data, valid the cycle after a read |
| norm_irq | output | 1 | Normal bank request |
| fast_irq | output | 1 | Fast bank request |

## Verification
The bench builds the controller with eight lines. At that width every input pattern can be swept against several polarity and enable words, and the enable register can be swept through all of its values. Expected source, status and output are computed as XOR and AND of the driven words. The narrow width also makes it practical to place an edge and its acknowledge in the same clock and to measure the exact sync-to-output latency.

// File: rtl/intc_pkg.sv
package intc_pkg;

    typedef enum logic [2:0] {
        REG_SRC  = 3'd0,
        REG_EN   = 3'd1,
        REG_ACK  = 3'd2,
        REG_MODE = 3'd3,
        REG_POL  = 3'd4,
        REG_STAT = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic en;
        logic ack;
        logic mode;
        logic pol;
    } bank_we_t;

    localparam int BANK_STRIDE_BIT = 5;

endpackage

// File: rtl/intc_sync.sv
module intc_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] raw_i,
    output logic [W-1:0] cur_o,
    output logic [W-1:0] prev_o
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] prev_q;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= raw_i;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q[s] <= '0;
                else        stg_q[s] <= stg_q[s-1];
            end
        end
    end

    // one extra stage shared by both banks for edge comparison
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= stg_q[STAGES-1];
    end

    assign cur_o  = stg_q[STAGES-1];
    assign prev_o = prev_q;
endmodule

// File: rtl/intc_bank.sv
module intc_bank
    import intc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] cur_i,
    input  logic [W-1:0] prev_i,
    input  bank_we_t     we_i,
    input  logic [W-1:0] wdata_i,
    output logic [W-1:0] src_o,
    output logic [W-1:0] en_o,
    output logic [W-1:0] mode_o,
    output logic [W-1:0] pol_o,
    output logic [W-1:0] stat_o,
    output logic         req_o
);
    logic [W-1:0] en_q, mode_q, pol_q, pend_q;
    logic [W-1:0] act_now, act_old, edge_w, ack_w, src_w, stat_w;
    logic         req_q;

    always_comb begin
        act_now = cur_i ^ pol_q;
        act_old = prev_i ^ pol_q;
        edge_w  = act_now & ~act_old;
        ack_w   = we_i.ack ? wdata_i : '0;
        src_w   = (mode_q & pend_q) | (~mode_q & act_now);
        stat_w  = src_w & en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q   <= '0;
            mode_q <= '0;
            pol_q  <= '0;
        end else begin
            if (we_i.en)   en_q   <= wdata_i;
            if (we_i.mode) mode_q <= wdata_i;
            if (we_i.pol)  pol_q  <= wdata_i;
        end
    end

    // edge set wins over acknowledge in the same cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= mode_q & ((pend_q & ~ack_w) | edge_w);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b0;
        else        req_q <= |stat_w;
    end

    assign src_o  = src_w;
    assign en_o   = en_q;
    assign mode_o = mode_q;
    assign pol_o  = pol_q;
    assign stat_o = stat_w;
    assign req_o  = req_q;

    for (genvar i = 0; i < W; i++) begin : g_line
        assert_edge_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[i] && pend_q[i] && !ack_w[i]) |=> (pend_q[i] || !mode_q[i]));
        assert_edge_captured_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (mode_q[i] && edge_w[i]) |=> (pend_q[i] || !mode_q[i]));
    end

    assert_req_follows_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        req_q |-> $past(stat_w != '0));
    assert_enable_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i.en |=> $stable(en_q));
endmodule

// File: rtl/intc_regif.sv
module intc_regif
    import intc_pkg::*;
#(
    parameter int W      = 32,
    parameter int ADDR_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              wr_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [W-1:0]      src0_i,
    input  logic [W-1:0]      en0_i,
    input  logic [W-1:0]      mode0_i,
    input  logic [W-1:0]      pol0_i,
    input  logic [W-1:0]      stat0_i,
    input  logic [W-1:0]      src1_i,
    input  logic [W-1:0]      en1_i,
    input  logic [W-1:0]      mode1_i,
    input  logic [W-1:0]      pol1_i,
    input  logic [W-1:0]      stat1_i,
    output bank_we_t          we0_o,
    output bank_we_t          we1_o,
    output logic [W-1:0]      rdata_o
);
    localparam int HI_W = ADDR_W - BANK_STRIDE_BIT - 1;

    logic     hit, bank1;
    reg_sel_e rsel;
    bank_we_t we_any;
    logic [W-1:0] rd_next, rdata_q;

    always_comb begin
        hit   = (addr_i[ADDR_W-1 -: HI_W] == '0) && (addr_i[1:0] == 2'b00)
              && (addr_i[4:2] <= 3'd5);
        bank1 = addr_i[BANK_STRIDE_BIT];
        rsel  = reg_sel_e'(addr_i[4:2]);

        we_any      = '0;
        if (sel_i && wr_i && hit) begin
            unique case (rsel)
                REG_EN:   we_any.en   = 1'b1;
                REG_ACK:  we_any.ack  = 1'b1;
                REG_MODE: we_any.mode = 1'b1;
                REG_POL:  we_any.pol  = 1'b1;
                default:  we_any      = '0;
            endcase
        end
        we0_o = bank1 ? '0 : we_any;
        we1_o = bank1 ? we_any : '0;

        rd_next = '0;
        if (hit) begin
            unique case (rsel)
                REG_SRC:  rd_next = bank1 ? src1_i  : src0_i;
                REG_EN:   rd_next = bank1 ? en1_i   : en0_i;
                REG_MODE: rd_next = bank1 ? mode1_i : mode0_i;
                REG_POL:  rd_next = bank1 ? pol1_i  : pol0_i;
                REG_STAT: rd_next = bank1 ? stat1_i : stat0_i;
                default:  rd_next = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              rdata_q <= '0;
        else if (sel_i && !wr_i) rdata_q <= rd_next;
    end

    assign rdata_o = rdata_q;

    assert_ack_reads_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i && hit && rsel == REG_ACK) |=> (rdata_q == '0));
    assert_unmapped_reads_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_i && !wr_i && !hit) |=> (rdata_q == '0));
    assert_single_bank_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !((|we0_o) && (|we1_o)));
endmodule

// File: rtl/intc_dualbank.sv
module intc_dualbank
    import intc_pkg::*;
#(
    parameter int NUM_LINES   = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_in,
    input  logic                 bus_sel,
    input  logic                 bus_wr,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic [NUM_LINES-1:0] bus_wdata,
    output logic [NUM_LINES-1:0] bus_rdata,
    output logic                 norm_irq,
    output logic                 fast_irq
);
    logic [NUM_LINES-1:0] cur, prev;
    logic [NUM_LINES-1:0] src0, en0, mode0, pol0, stat0;
    logic [NUM_LINES-1:0] src1, en1, mode1, pol1, stat1;
    bank_we_t we0, we1;

    intc_sync #(.W(NUM_LINES), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .raw_i(line_in), .cur_o(cur), .prev_o(prev)
    );

    intc_bank #(.W(NUM_LINES)) u_norm (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev),
        .we_i(we0), .wdata_i(bus_wdata),
        .src_o(src0), .en_o(en0), .mode_o(mode0), .pol_o(pol0),
        .stat_o(stat0), .req_o(norm_irq)
    );

    intc_bank #(.W(NUM_LINES)) u_fast (
        .clk(clk), .rst_n(rst_n), .cur_i(cur), .prev_i(prev),
        .we_i(we1), .wdata_i(bus_wdata),
        .src_o(src1), .en_o(en1), .mode_o(mode1), .pol_o(pol1),
        .stat_o(stat1), .req_o(fast_irq)
    );

    intc_regif #(.W(NUM_LINES), .ADDR_W(ADDR_W)) u_regif (
        .clk(clk), .rst_n(rst_n),
        .sel_i(bus_sel), .wr_i(bus_wr), .addr_i(bus_addr),
        .src0_i(src0), .en0_i(en0), .mode0_i(mode0), .pol0_i(pol0), .stat0_i(stat0),
        .src1_i(src1), .en1_i(en1), .mode1_i(mode1), .pol1_i(pol1), .stat1_i(stat1),
        .we0_o(we0), .we1_o(we1), .rdata_o(bus_rdata)
    );

    assert_reset_quiet_R2: assert property (@(posedge clk)
        !rst_n |=> (!norm_irq && !fast_irq));
endmodule

// File: tb/tb_intc_dualbank.sv
module tb_intc_dualbank;
    localparam int N = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] line_in = '0;
    logic         bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata;
    logic         norm_irq, fast_irq;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    intc_dualbank #(.NUM_LINES(N), .ADDR_W(8), .SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .line_in(line_in),
        .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .norm_irq(norm_irq), .fast_irq(fast_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [N-1:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        @(posedge clk);
        @(negedge clk);
        d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic settle();
        repeat (5) @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [N-1:0] v;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R2 norm_irq in reset", norm_irq, 0);
        rst_n = 1'b1;

        // R2: reset values of both banks
        rd(8'h04, v); chk("R2 en reset", v, 0);
        rd(8'h0C, v); chk("R2 mode reset", v, 0);
        rd(8'h10, v); chk("R2 pol reset", v, 0);
        rd(8'h24, v); chk("R2 fast en reset", v, 0);
        rd(8'h2C, v); chk("R2 fast mode reset", v, 0);
        rd(8'h30, v); chk("R2 fast pol reset", v, 0);
        chk("R2 fast_irq reset", fast_irq, 0);

        // R1: full sweep of normal enable, spot values for the others
        for (int k = 0; k < 256; k++) begin
            wr(8'h04, N'(k)); rd(8'h04, v); chk("R1 en readback", v, k);
        end
        wr(8'h0C, 8'h5A); rd(8'h0C, v); chk("R1 mode readback", v, 8'h5A);
        wr(8'h10, 8'hC3); rd(8'h10, v); chk("R1 pol readback", v, 8'hC3);
        wr(8'h24, 8'h96); rd(8'h24, v); chk("R1 fast en readback", v, 8'h96);
        wr(8'h2C, 8'h3C); rd(8'h2C, v); chk("R1 fast mode readback", v, 8'h3C);
        wr(8'h30, 8'h0F); rd(8'h30, v); chk("R1 fast pol readback", v, 8'h0F);
        rd(8'h04, v); chk("R9 norm en untouched by fast writes", v, 8'hFF);
        wr(8'h24, 8'h00); wr(8'h2C, 8'h00); wr(8'h30, 8'h00);

        // R3 R4 R5 R8: level sweep over input words
        wr(8'h0C, 8'h00);
        for (int p = 0; p < 3; p++) begin
            logic [N-1:0] pol, en;
            pol = (p == 0) ? 8'h00 : (p == 1) ? 8'hFF : 8'hA5;
            en  = (p == 2) ? 8'h3C : 8'hFF;
            wr(8'h10, pol); wr(8'h04, en);
            for (int k = 0; k < 256; k++) begin
                @(negedge clk); line_in = N'(k);
                settle();
                chk("R8 norm_irq is OR of status", norm_irq, int'(|((N'(k) ^ pol) & en)));
                rd(8'h00, v); chk("R5 R4 level source", v, int'(N'(k) ^ pol));
                rd(8'h14, v); chk("R3 status masked", v, int'((N'(k) ^ pol) & en));
            end
        end

        // R8: exact latency of a level change
        wr(8'h10, 8'h00); wr(8'h04, 8'hFF);
        @(negedge clk); line_in = 8'h00; settle();
        line_in = 8'h02;
        repeat (2) @(posedge clk); @(negedge clk);
        chk("R8 norm_irq low after two edges", norm_irq, 0);
        @(posedge clk); @(negedge clk);
        chk("R8 norm_irq high at third edge", norm_irq, 1);

        // R7: acknowledge on level lines
        @(negedge clk); line_in = 8'h81; settle();
        wr(8'h08, 8'hFF); settle();
        rd(8'h00, v); chk("R7 level source survives ack", v, 8'h81);
        rd(8'h08, v); chk("R7 ack reads zero", v, 0);

        // R6: edges, lines 0-3 falling, 4-7 rising
        @(negedge clk); line_in = 8'h00; settle();
        wr(8'h10, 8'h0F); wr(8'h0C, 8'hFF); wr(8'h08, 8'hFF);
        rd(8'h00, v); chk("R6 edge source clear", v, 0);
        @(negedge clk); line_in = 8'hFF; settle();
        rd(8'h00, v); chk("R6 R4 rising edges latched", v, 8'hF0);
        chk("R8 norm_irq on edge", norm_irq, 1);
        wr(8'h08, 8'hF0); settle();
        rd(8'h00, v); chk("R6 ack clears while input high", v, 0);
        chk("R6 norm_irq drops after ack", norm_irq, 0);
        @(negedge clk); line_in = 8'h00; settle();
        rd(8'h00, v); chk("R6 R4 falling edges latched", v, 8'h0F);
        wr(8'h08, 8'h05);
        rd(8'h00, v); chk("R6 zero ack bits keep pending", v, 8'h0A);
        wr(8'h04, 8'h00); settle();
        rd(8'h14, v); chk("R3 disabled status", v, 0);
        rd(8'h00, v); chk("R3 source kept while disabled", v, 8'h0A);
        chk("R3 norm_irq low while disabled", norm_irq, 0);
        wr(8'h04, 8'hFF); settle();
        chk("R3 norm_irq after enable", norm_irq, 1);
        wr(8'h08, 8'hFF);

        // R6: edge and ack in the same cycle, line 0 falling
        @(negedge clk); line_in = 8'h01; settle();
        wr(8'h08, 8'hFF);
        @(negedge clk); line_in = 8'h00;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h08; bus_wdata = 8'h01;
        @(posedge clk); @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        rd(8'h00, v); chk("R6 edge wins over ack", v, 8'h01);
        wr(8'h08, 8'hFF);
        rd(8'h00, v); chk("R6 later ack clears", v, 0);

        // R9: fast bank independent of normal bank
        wr(8'h04, 8'h00); wr(8'h0C, 8'h00); wr(8'h10, 8'h00);
        wr(8'h30, 8'hFF); wr(8'h24, 8'hFF);
        @(negedge clk); line_in = 8'h0F; settle();
        rd(8'h20, v); chk("R9 fast source", v, 8'hF0);
        rd(8'h34, v); chk("R9 fast status", v, 8'hF0);
        rd(8'h00, v); chk("R9 norm source", v, 8'h0F);
        rd(8'h14, v); chk("R9 norm status", v, 0);
        chk("R9 fast_irq high", fast_irq, 1);
        chk("R9 norm_irq low", norm_irq, 0);

        // R10: unmapped addresses
        wr(8'h18, 8'h00); wr(8'h44, 8'h00); wr(8'h25, 8'h00);
        rd(8'h24, v); chk("R10 writes to unmapped ignored", v, 8'hFF);
        rd(8'h18, v); chk("R10 unmapped 0x18 reads zero", v, 0);
        rd(8'h60, v); chk("R10 unmapped 0x60 reads zero", v, 0);
        rd(8'h3C, v); chk("R10 unmapped 0x3C reads zero", v, 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule